// File: doc/BRIEF.md
# BCD Timekeeper Register Bank

This block is a byte-wide, SRAM-style memory with a calendar clock folded into its eight highest byte addresses. A synchronous bus (enable, write-enable, 15-bit address, 8-bit data) reaches both parts. Addresses below the clock window go to a plain byte RAM. The eight window bytes are holding registers, kept apart from the live second/minute/hour/day/date/month/year counters.

The counters advance on a one-cycle 1 Hz tick pulse. On the clock edge after that tick, all seven time bytes are refreshed together from the counters, unless software has frozen them. Software freezes them either to take a stable snapshot (read-hold bit) or to set the time (set bit). When the set bit is cleared, the seven time bytes are copied into the counters in one cycle. The block also has an oscillator stop bit, a century flag that flips at the year 99 to 00 wrap, and a frequency-test mode. In that mode bit 0 of the seconds byte is replaced by a square wave that toggles on every pulse of a 1024 Hz strobe, which gives a 512 Hz output.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the window reads: control (offset 0) 0x00; seconds (offset 1) 0x80, which is stop set and 00 seconds; minutes (2) 0x00; hours (3) 0x00; century/day (4) 0x01; date (5) 0x01; month (6) 0x01; year (7) 0x00. The window is addresses 0x7FF8 to 0x7FFF, with offset = address minus 0x7FF8.
- R2: Addresses below 2^RAM_AW (1024 by default) are RAM. A write followed by a read returns the data one cycle after the read is accepted. Other addresses outside the window drop writes and read 0x00, and a write there does not alias into the RAM.
- R3: Every value is packed BCD. With stop clear, a tick pulse advances the counters by one second. The holding bytes show the new time from the clock edge after the tick. Seconds carry 09 to 10 in BCD.
- R4: Seconds and minutes wrap 59 to 00, and hours wrap 23 to 00 (24-hour). At midnight the day field (century/day bits 2:0) goes 7 to 1, or otherwise up by one, and the date goes up by one.
- R5: The date wraps to 01 and the month advances after the last day of the month. That day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on 29 when the year is divisible by 4 and on 28 otherwise. Month 12 wraps to 01 and the year advances.
- R6: The year wraps 99 to 00. At that wrap the century bit (century/day bit 4) inverts if century-enable (bit 5) is 1, and is unchanged if it is 0.
- R7: With the stop bit (seconds bit 7) at 1, ticks do not advance the counters. Once it is cleared, the next tick advances them.
- R8: While the read-hold bit (control bit 6) is 1, ticks do not refresh the holding bytes. After it is cleared, the next tick shows the counter time, which kept running in the meantime.
- R9: While the set bit (control bit 7) is 1, ticks do not refresh the holding bytes, and user writes to the time bytes stay in place. Writing control with bit 7 clear while it was set copies all seven time bytes into the counters on that edge.
- R10: Century-enable, frequency-test and day can be written at any time. The century bit takes a written value only while the set bit is 1, and otherwise keeps its value.
- R11: Bits defined as zero read 0 whatever is written: minutes bit 7, hours bits 7:6, century/day bits 7 and 3, date bits 7:6, month bits 7:5.
- R12: When frequency-test (century/day bit 6) is 1 and stop is 0, a read of the seconds byte returns a square-wave level in bit 0. That level starts at 0 after reset and inverts on each 1024 Hz strobe pulse. Otherwise the stored seconds byte is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second that advances the counters |
| tick_1024hz | input | 1 | One-cycle pulse at 1024 Hz that toggles the test square wave |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read when bus_en is high |
| bus_addr | input | ADDR_W (15) | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read is accepted, held until the next read |

## Verification
A read accepted on one edge shows its data from that edge onward, so the monitor compares on the following falling edge. It uses a one-cycle delayed copy of the read strobe to pop the expected byte. The counters step on the edge that samples a tick, and the holding bytes copy them one edge later. The tick task therefore spans two full cycles before any read is issued, so every time-of-day check sees the refreshed value. Loads on clearing the set bit take effect on the write edge, and the following tick shows the loaded time plus one second.

// File: rtl/tk_pkg.sv
package tk_pkg;

  localparam int NUM_BYTES = 8;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_SEC  = 3'd1;
  localparam logic [2:0] OFS_MIN  = 3'd2;
  localparam logic [2:0] OFS_HR   = 3'd3;
  localparam logic [2:0] OFS_CDAY = 3'd4;
  localparam logic [2:0] OFS_DATE = 3'd5;
  localparam logic [2:0] OFS_MON  = 3'd6;
  localparam logic [2:0] OFS_YR   = 3'd7;

  localparam int BIT_SET  = 7;  // control: set mode
  localparam int BIT_HOLD = 6;  // control: read-hold
  localparam int BIT_STOP = 7;  // seconds: oscillator stop
  localparam int BIT_FT   = 6;  // century/day: frequency test
  localparam int BIT_CEN  = 5;  // century/day: century enable
  localparam int BIT_CENT = 4;  // century/day: century flag

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hr;
    logic [2:0] day;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] yr;
    logic       cent;
  } tk_time_t;

  typedef logic [NUM_BYTES-1:0][7:0] tk_bytes_t;

  typedef enum logic [1:0] {SRC_NONE, SRC_RAM, SRC_WIN} tk_src_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Divisible by 4 in BCD: odd tens with units 2/6, even tens with units 0/4/8.
  function automatic logic is_leap(input logic [7:0] yr);
    logic r;
    if (yr[4]) r = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       r = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return r;
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] mon, input logic [7:0] yr);
    logic [5:0] r;
    case (mon)
      5'h02:                      r = is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] byte_mask(input logic [2:0] ofs);
    logic [7:0] r;
    case (ofs)
      OFS_MIN:  r = 8'h7F;
      OFS_HR:   r = 8'h3F;
      OFS_CDAY: r = 8'h77;
      OFS_DATE: r = 8'h3F;
      OFS_MON:  r = 8'h1F;
      default:  r = 8'hFF;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] reset_byte(input logic [2:0] ofs);
    logic [7:0] r;
    case (ofs)
      OFS_SEC:  r = 8'h80;
      OFS_CDAY: r = 8'h01;
      OFS_DATE: r = 8'h01;
      OFS_MON:  r = 8'h01;
      default:  r = 8'h00;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] merge_write(input logic [2:0] ofs, input logic [7:0] old,
                                             input logic [7:0] wd, input logic set_mode);
    logic [7:0] r;
    r = wd & byte_mask(ofs);
    if (ofs == OFS_CDAY && !set_mode) r[BIT_CENT] = old[BIT_CENT];
    return r;
  endfunction

  function automatic logic [7:0] refresh_byte(input logic [2:0] ofs, input logic [7:0] old,
                                              input tk_time_t t);
    logic [7:0] r;
    case (ofs)
      OFS_SEC:  r = {old[BIT_STOP], t.sec};
      OFS_MIN:  r = {1'b0, t.min};
      OFS_HR:   r = {2'b00, t.hr};
      OFS_CDAY: r = {1'b0, old[BIT_FT], old[BIT_CEN], t.cent, 1'b0, t.day};
      OFS_DATE: r = {2'b00, t.date};
      OFS_MON:  r = {3'b000, t.mon};
      OFS_YR:   r = t.yr;
      default:  r = old;
    endcase
    return r;
  endfunction

  function automatic tk_time_t bytes_to_time(input tk_bytes_t b);
    tk_time_t t;
    t.sec  = b[OFS_SEC][6:0];
    t.min  = b[OFS_MIN][6:0];
    t.hr   = b[OFS_HR][5:0];
    t.day  = b[OFS_CDAY][2:0];
    t.date = b[OFS_DATE][5:0];
    t.mon  = b[OFS_MON][4:0];
    t.yr   = b[OFS_YR];
    t.cent = b[OFS_CDAY][BIT_CENT];
    return t;
  endfunction

  function automatic tk_time_t time_reset();
    tk_time_t t;
    t.sec  = '0;
    t.min  = '0;
    t.hr   = '0;
    t.day  = 3'd1;
    t.date = 6'h01;
    t.mon  = 5'h01;
    t.yr   = '0;
    t.cent = 1'b0;
    return t;
  endfunction

endpackage

// File: rtl/tk_byte_ram.sv
module tk_byte_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/tk_counter_chain.sv
module tk_counter_chain import tk_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     run,
  input  logic     load,
  input  tk_time_t load_val,
  input  logic     cen_en,
  output tk_time_t cnt
);
  tk_time_t nxt;
  logic [7:0] sec_i, min_i, hr_i, date_i, mon_i, yr_i;
  logic c_sec, c_min, c_hr, c_date, c_mon;

  always_comb begin
    sec_i  = bcd_inc({1'b0, cnt.sec});
    min_i  = bcd_inc({1'b0, cnt.min});
    hr_i   = bcd_inc({2'b00, cnt.hr});
    date_i = bcd_inc({2'b00, cnt.date});
    mon_i  = bcd_inc({3'b000, cnt.mon});
    yr_i   = bcd_inc(cnt.yr);
    c_sec  = (cnt.sec == 7'h59);
    c_min  = c_sec && (cnt.min == 7'h59);
    c_hr   = c_min && (cnt.hr == 6'h23);
    c_date = c_hr && (cnt.date == month_last(cnt.mon, cnt.yr));
    c_mon  = c_date && (cnt.mon == 5'h12);

    nxt = cnt;
    nxt.sec = c_sec ? 7'h00 : sec_i[6:0];
    if (c_sec) nxt.min = (cnt.min == 7'h59) ? 7'h00 : min_i[6:0];
    if (c_min) nxt.hr  = (cnt.hr == 6'h23) ? 6'h00 : hr_i[5:0];
    if (c_hr) begin
      nxt.day  = (cnt.day == 3'd7) ? 3'd1 : cnt.day + 3'd1;
      nxt.date = c_date ? 6'h01 : date_i[5:0];
    end
    if (c_date) nxt.mon = c_mon ? 5'h01 : mon_i[4:0];
    if (c_mon) begin
      nxt.yr = (cnt.yr == 8'h99) ? 8'h00 : yr_i;
      if (cnt.yr == 8'h99 && cen_en) nxt.cent = ~cnt.cent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= time_reset();
    else if (load)        cnt <= load_val;
    else if (tick && run) cnt <= nxt;
  end
endmodule

// File: rtl/tk_window_regs.sv
module tk_window_regs import tk_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_ofs,
  input  logic [7:0] wr_data,
  input  logic       refresh,
  input  tk_time_t   cnt,
  output tk_bytes_t  bytes,
  output logic       halt,
  output logic       load
);
  logic [7:0] byte_q [NUM_BYTES];
  logic       set_mode;

  assign set_mode = byte_q[OFS_CTRL][BIT_SET];
  assign halt     = byte_q[OFS_CTRL][BIT_SET] | byte_q[OFS_CTRL][BIT_HOLD];
  assign load     = wr_en && (wr_ofs == OFS_CTRL) && set_mode && !wr_data[BIT_SET];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    localparam logic [2:0] OFS = 3'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byte_q[g] <= reset_byte(OFS);
      else if (wr_en && wr_ofs == OFS)
        byte_q[g] <= merge_write(OFS, byte_q[g], wr_data, set_mode);
      else if (refresh && !halt && OFS != OFS_CTRL)
        byte_q[g] <= refresh_byte(OFS, byte_q[g], cnt);
    end
    assign bytes[g] = byte_q[g];
  end
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper import tk_pkg::*; #(
  parameter int ADDR_W = 15,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              tick_1024hz,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  localparam int WIN_AW = 3;

  logic      win_hit, ram_hit;
  logic      win_wr, win_rd, ram_wr, ram_rd, bus_rd;
  logic      upd_evt, sq512;
  logic      halt_now, load_evt, stop_now, ft_on, cen_en;
  tk_bytes_t win_bytes;
  tk_time_t  cnt_q, load_val;
  logic [7:0] win_byte, win_rdata_q, ram_q;
  tk_src_e   src_q;

  assign win_hit = &bus_addr[ADDR_W-1:WIN_AW];
  assign ram_hit = (bus_addr >> RAM_AW) == '0;
  assign bus_rd  = bus_en && !bus_we;
  assign win_wr  = bus_en && bus_we && win_hit;
  assign win_rd  = bus_rd && win_hit;
  assign ram_wr  = bus_en && bus_we && ram_hit;
  assign ram_rd  = bus_rd && ram_hit;

  assign stop_now = win_bytes[OFS_SEC][BIT_STOP];
  assign ft_on    = win_bytes[OFS_CDAY][BIT_FT];
  assign cen_en   = win_bytes[OFS_CDAY][BIT_CEN];
  assign load_val = bytes_to_time(win_bytes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_evt <= 1'b0;
      sq512   <= 1'b0;
    end else begin
      upd_evt <= tick_1hz;
      if (tick_1024hz) sq512 <= ~sq512;
    end
  end

  tk_counter_chain u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_1hz),
    .run      (!stop_now),
    .load     (load_evt),
    .load_val (load_val),
    .cen_en   (cen_en),
    .cnt      (cnt_q)
  );

  tk_window_regs u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (win_wr),
    .wr_ofs  (bus_addr[WIN_AW-1:0]),
    .wr_data (bus_wdata),
    .refresh (upd_evt),
    .cnt     (cnt_q),
    .bytes   (win_bytes),
    .halt    (halt_now),
    .load    (load_evt)
  );

  tk_byte_ram #(.AW(RAM_AW), .DW(8)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_wr),
    .re    (ram_rd),
    .addr  (bus_addr[RAM_AW-1:0]),
    .wdata (bus_wdata),
    .rdata (ram_q)
  );

  always_comb begin
    win_byte = win_bytes[bus_addr[WIN_AW-1:0]];
    if (bus_addr[WIN_AW-1:0] == OFS_SEC && ft_on && !stop_now) win_byte[0] = sq512;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q       <= SRC_NONE;
      win_rdata_q <= '0;
    end else begin
      if (bus_rd) src_q <= win_hit ? SRC_WIN : (ram_hit ? SRC_RAM : SRC_NONE);
      if (win_rd) win_rdata_q <= win_byte;
    end
  end

  always_comb begin
    case (src_q)
      SRC_WIN: bus_rdata = win_rdata_q;
      SRC_RAM: bus_rdata = ram_q;
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/tk_checker.sv
module tk_checker import tk_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       stop,
  input logic       halt,
  input logic       load,
  input logic       win_wr,
  input tk_time_t   cnt,
  input tk_time_t   load_val,
  input logic [7:0] hold_min
);
  AST_SEC_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt.sec[3:0] <= 4'd9) && (cnt.sec <= 7'h59)); // R3

  AST_TICK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && !load) |=> (cnt.sec != $past(cnt.sec))); // R3

  AST_HR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt.hr <= 6'h23) && (cnt.hr[3:0] <= 4'd9)); // R4

  AST_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt.date != 6'h00) && (cnt.date <= month_last(cnt.mon, cnt.yr))); // R5

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load) |=> $stable(cnt)); // R7

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !win_wr) |=> $stable(hold_min)); // R8

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val))); // R9
endmodule

bind bcd_timekeeper tk_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick_1hz),
  .stop     (stop_now),
  .halt     (halt_now),
  .load     (load_evt),
  .win_wr   (win_wr),
  .cnt      (cnt_q),
  .load_val (load_val),
  .hold_min (win_bytes[2])
);

// File: tb/bcd_timekeeper_tb_top.sv
module bcd_timekeeper_tb_top;
  localparam logic [14:0] A_CTRL = 15'h7FF8;
  localparam logic [14:0] A_SEC  = 15'h7FF9;
  localparam logic [14:0] A_MIN  = 15'h7FFA;
  localparam logic [14:0] A_HR   = 15'h7FFB;
  localparam logic [14:0] A_CDAY = 15'h7FFC;
  localparam logic [14:0] A_DATE = 15'h7FFD;
  localparam logic [14:0] A_MON  = 15'h7FFE;
  localparam logic [14:0] A_YR   = 15'h7FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 1'b0, tick_1024hz = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [14:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  always #5 clk = ~clk;

  bcd_timekeeper dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_1024hz(tick_1024hz),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int checks = 0, errors = 0, sq_cnt = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [14:0] adr_q[$];
  logic rd_q = 1'b0;

  always @(posedge clk) rd_q <= bus_en && !bus_we;

  // Monitor: data of a read accepted at an edge is compared at the next falling edge.
  always @(negedge clk) begin
    if (rd_q) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual=%h expected=<none>", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        logic [14:0] a;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = adr_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s addr=%h actual=%h expected=%h", t, a, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [14:0] a, input logic [7:0] e, input string t);
    bus_en = 1; bus_we = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t); adr_q.push_back(a);
    @(negedge clk);
    bus_en = 0;
  endtask

  // Counter step on the tick edge, holding refresh one edge later.
  task automatic tick();
    tick_1hz = 1;
    @(negedge clk);
    tick_1hz = 0;
    @(negedge clk);
  endtask

  task automatic ftick();
    tick_1024hz = 1;
    @(negedge clk);
    tick_1024hz = 0;
    sq_cnt++;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] cd, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] y);
    wr(A_CTRL, 8'h80);
    wr(A_SEC, s); wr(A_MIN, m); wr(A_HR, h); wr(A_CDAY, cd);
    wr(A_DATE, dt); wr(A_MON, mo); wr(A_YR, y);
    wr(A_CTRL, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset contents
    rd(A_CTRL, 8'h00, "R1"); rd(A_SEC, 8'h80, "R1"); rd(A_MIN, 8'h00, "R1");
    rd(A_HR, 8'h00, "R1"); rd(A_CDAY, 8'h01, "R1"); rd(A_DATE, 8'h01, "R1");
    rd(A_MON, 8'h01, "R1"); rd(A_YR, 8'h00, "R1");

    // R2 RAM and unmapped space
    wr(15'h0012, 8'hA5); wr(15'h03FF, 8'h5A); wr(15'h0000, 8'h11); wr(15'h0400, 8'h33);
    rd(15'h0012, 8'hA5, "R2"); rd(15'h03FF, 8'h5A, "R2");
    rd(15'h0000, 8'h11, "R2"); rd(15'h0400, 8'h00, "R2");

    // R11 zero bits
    wr(A_CTRL, 8'h80);
    wr(A_MIN, 8'hFF); rd(A_MIN, 8'h7F, "R11");
    wr(A_HR, 8'hFF); rd(A_HR, 8'h3F, "R11");
    wr(A_DATE, 8'hFF); rd(A_DATE, 8'h3F, "R11");
    wr(A_MON, 8'hFF); rd(A_MON, 8'h1F, "R11");
    wr(A_CDAY, 8'hFF); rd(A_CDAY, 8'h77, "R11");

    // R3 one-second step and BCD carry
    set_time(8'h30, 8'h20, 8'h10, 8'h02, 8'h15, 8'h06, 8'h21);
    tick();
    rd(A_SEC, 8'h31, "R3"); rd(A_MIN, 8'h20, "R3"); rd(A_HR, 8'h10, "R3");
    set_time(8'h09, 8'h20, 8'h10, 8'h02, 8'h15, 8'h06, 8'h21);
    tick();
    rd(A_SEC, 8'h10, "R3");

    // R4 midnight rollover
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h10, 8'h03, 8'h22);
    tick();
    rd(A_SEC, 8'h00, "R4"); rd(A_MIN, 8'h00, "R4"); rd(A_HR, 8'h00, "R4");
    rd(A_CDAY, 8'h01, "R4"); rd(A_DATE, 8'h11, "R4"); rd(A_MON, 8'h03, "R4");

    // R5 February end across years, then a 30-day month and a 31-day month
    for (int i = 0; i < 4; i++) begin
      int y;
      logic [7:0] yb;
      bit lp;
      y  = (i == 0) ? 1 : (i == 1) ? 4 : (i == 2) ? 10 : 12;
      yb = {4'(y / 10), 4'(y % 10)};
      lp = (y % 4) == 0;
      set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, yb);
      tick();
      rd(A_DATE, lp ? 8'h29 : 8'h01, "R5");
      rd(A_MON, lp ? 8'h02 : 8'h03, "R5");
    end
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h21);
    tick();
    rd(A_DATE, 8'h01, "R5"); rd(A_MON, 8'h05, "R5");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h01, 8'h21);
    tick();
    rd(A_DATE, 8'h01, "R5"); rd(A_MON, 8'h02, "R5");

    // R6 year wrap with and without century enable
    set_time(8'h59, 8'h59, 8'h23, 8'h23, 8'h31, 8'h12, 8'h99);
    tick();
    rd(A_YR, 8'h00, "R6"); rd(A_MON, 8'h01, "R6"); rd(A_CDAY, 8'h34, "R6");
    set_time(8'h59, 8'h59, 8'h23, 8'h33, 8'h31, 8'h12, 8'h99);
    tick();
    rd(A_CDAY, 8'h24, "R6");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99);
    tick();
    rd(A_YR, 8'h00, "R6"); rd(A_CDAY, 8'h04, "R6");

    // R7 stop bit
    set_time(8'h90, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h23);
    tick();
    rd(A_SEC, 8'h90, "R7");
    wr(A_SEC, 8'h10);
    tick();
    rd(A_SEC, 8'h11, "R7");

    // R8 read-hold snapshot
    set_time(8'h05, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h23);
    wr(A_CTRL, 8'h40);
    tick();
    rd(A_SEC, 8'h05, "R8"); rd(A_CTRL, 8'h40, "R8");
    wr(A_CTRL, 8'h00);
    tick();
    rd(A_SEC, 8'h07, "R8");

    // R9 set mode and load on clear
    set_time(8'h20, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h23);
    wr(A_CTRL, 8'h80);
    tick();
    rd(A_SEC, 8'h20, "R9");
    wr(A_SEC, 8'h42);
    rd(A_SEC, 8'h42, "R9");
    wr(A_CTRL, 8'h00);
    rd(A_SEC, 8'h42, "R9");
    tick();
    rd(A_SEC, 8'h43, "R9");

    // R10 century flag write rule
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h23);
    wr(A_CDAY, 8'h31);
    rd(A_CDAY, 8'h21, "R10");
    wr(A_CTRL, 8'h80);
    wr(A_CDAY, 8'h31);
    rd(A_CDAY, 8'h31, "R10");
    wr(A_CTRL, 8'h00);
    tick();
    rd(A_CDAY, 8'h31, "R10");

    // R12 frequency test on seconds bit 0
    set_time(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h23);
    wr(A_CDAY, 8'h41);
    rd(A_SEC, 8'h20 | 8'(sq_cnt % 2), "R12");
    ftick();
    rd(A_SEC, 8'h20 | 8'(sq_cnt % 2), "R12");
    wr(A_SEC, 8'hA0);
    rd(A_SEC, 8'hA0, "R12");
    wr(A_SEC, 8'h20);
    wr(A_CDAY, 8'h01);
    rd(A_SEC, 8'h20, "R12");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule